// File: doc/BRIEF.md
# Scaled Index Load Address Generator

This block forms the effective address for a family of load operations whose index operand is scaled before it is added. The index register value is shifted left by one more than a two-bit scale field, so the scale is 2, 4, 8 or 16. The shifted index is then added to a base term, and the sum wraps at the register width. The caller supplies the operand values that the register file has already read, the register numbers of the base and of the target, the scale field and a flag that marks the update form.

In the plain form, base register number zero stands for a literal zero base. In the update form, the base term is always the value of the named base register, and the block asks for that register to be written back with the effective address. An update form is malformed when it names register zero as its base, or when its base register is also its target. A malformed request raises a flag and gets no write-back. The block changes no status state.

All results are registered and appear one clock after the request is presented.

Top module: `sidx_agen`

## Requirements
- R1: For a valid request, `ea_o` one cycle later equals the base term plus (`index_i` shifted left by `scale_i`+1), taken modulo 2^XLEN. Bits shifted above XLEN and the carry out of the sum are discarded.
- R2: In a plain request (`upd_i`=0) with `base_sel_i`=0, the base term is zero whatever `base_i` holds.
- R3: In a plain request with `base_sel_i`≠0, the base term is `base_i`.
- R4: A well-formed update request (`upd_i`=1) uses `base_i` as the base term. One cycle later it drives `wb_en_o`=1, with `wb_sel_o` equal to `base_sel_i`.
- R5: An update request with `base_sel_i`=0 sets `bad_form_o`=1 one cycle later.
- R6: An update request with `base_sel_i`=`tgt_sel_i` sets `bad_form_o`=1 one cycle later.
- R7: When `bad_form_o` is 1, `wb_en_o` is 0.
- R8: A plain request never sets `wb_en_o` or `bad_form_o`.
- R9: While reset is held, and in the cycle after it, every output is zero.
- R10: `out_valid_o` follows `in_valid_i` with a one-cycle delay. In a cycle with no valid result, `ea_o`, `wb_en_o`, `wb_sel_o` and `bad_form_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request present this cycle |
| base_i | input | XLEN | Value read from the base register |
| index_i | input | XLEN | Value read from the index register |
| base_sel_i | input | RSEL_W | Base register number |
| tgt_sel_i | input | RSEL_W | Target register number |
| scale_i | input | 2 | Scale field; the index shift is scale_i+1 |
| upd_i | input | 1 | 1 marks the update form |
| out_valid_o | output | 1 | Result valid |
| ea_o | output | XLEN | Effective address |
| wb_en_o | output | 1 | Write the effective address back to the base register |
| wb_sel_o | output | RSEL_W | Register number for the write-back |
| bad_form_o | output | 1 | Update request is malformed |

## Verification
Every output is due exactly one clock after the request that caused it, because one register stage lies between inputs and outputs. The bench drives a request on a falling edge and computes its expected result at the same moment. It compares that result with the outputs on the next falling edge, after the single rising edge that loads them. Idle and reset cycles are compared the same way, against all-zero results. The stimulus covers every scale value, index values whose high bits are shifted out, a base plus index sum that wraps, register zero in both forms, base equal to target, and a pseudo-random run over a small set of register numbers so that these collisions occur often.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic {
        FORM_PLAIN = 1'b0,
        FORM_UPD   = 1'b1
    } form_kind_e;

    typedef struct packed {
        logic wb_ok;
        logic bad;
    } form_res_t;

    localparam int SCALE_W    = 2;
    localparam int SCALE_OPTS = 1 << SCALE_W;

    // number of bit positions the index moves for a given scale field
    function automatic int shift_of(input logic [SCALE_W-1:0] sc);
        return int'(sc) + 1;
    endfunction

endpackage

// File: rtl/agen_scale.sv
module agen_scale
    import agen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]    idx_i,
    input  logic [SCALE_W-1:0] sc_i,
    output logic [XLEN-1:0]    scaled_o
);
    logic [XLEN-1:0] opts [SCALE_OPTS];

    for (genvar s = 0; s < SCALE_OPTS; s++) begin : g_opt
        assign opts[s] = idx_i << shift_of(SCALE_W'(s));
    end

    assign scaled_o = opts[sc_i];
endmodule

// File: rtl/agen_base.sv
module agen_base
    import agen_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int RSEL_W = 5
) (
    input  logic [XLEN-1:0]   base_i,
    input  logic [RSEL_W-1:0] sel_i,
    input  form_kind_e        kind_i,
    output logic [XLEN-1:0]   term_o
);
    logic zero_reg;
    assign zero_reg = (sel_i == '0);

    always_comb begin
        if (kind_i == FORM_PLAIN && zero_reg) term_o = '0;
        else                                  term_o = base_i;
    end
endmodule

// File: rtl/agen_form.sv
module agen_form
    import agen_pkg::*;
#(
    parameter int RSEL_W = 5
) (
    input  logic [RSEL_W-1:0] base_sel_i,
    input  logic [RSEL_W-1:0] tgt_sel_i,
    input  form_kind_e        kind_i,
    output form_res_t         res_o
);
    logic clash;
    assign clash = (base_sel_i == '0) || (base_sel_i == tgt_sel_i);

    always_comb begin
        res_o = '0;
        if (kind_i == FORM_UPD) begin
            res_o.bad   = clash;
            res_o.wb_ok = !clash;
        end
    end

    always_comb begin
        AST_FORM_EXCL: assert (!(res_o.bad && res_o.wb_ok)); // R7
    end
endmodule

// File: rtl/sidx_agen.sv
module sidx_agen
    import agen_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int RSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   index_i,
    input  logic [RSEL_W-1:0] base_sel_i,
    input  logic [RSEL_W-1:0] tgt_sel_i,
    input  logic [1:0]        scale_i,
    input  logic              upd_i,
    output logic              out_valid_o,
    output logic [XLEN-1:0]   ea_o,
    output logic              wb_en_o,
    output logic [RSEL_W-1:0] wb_sel_o,
    output logic              bad_form_o
);
    form_kind_e      kind;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] term;
    logic [XLEN-1:0] sum;
    form_res_t       form;

    assign kind = upd_i ? FORM_UPD : FORM_PLAIN;

    agen_scale #(.XLEN(XLEN)) u_scale (
        .idx_i    (index_i),
        .sc_i     (scale_i),
        .scaled_o (scaled)
    );

    agen_base #(.XLEN(XLEN), .RSEL_W(RSEL_W)) u_base (
        .base_i (base_i),
        .sel_i  (base_sel_i),
        .kind_i (kind),
        .term_o (term)
    );

    agen_form #(.RSEL_W(RSEL_W)) u_form (
        .base_sel_i (base_sel_i),
        .tgt_sel_i  (tgt_sel_i),
        .kind_i     (kind),
        .res_o      (form)
    );

    assign sum = term + scaled;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            ea_o        <= '0;
            wb_en_o     <= 1'b0;
            wb_sel_o    <= '0;
            bad_form_o  <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            ea_o        <= in_valid_i ? sum : '0;
            wb_en_o     <= in_valid_i && form.wb_ok;
            wb_sel_o    <= in_valid_i ? base_sel_i : '0;
            bad_form_o  <= in_valid_i && form.bad;
        end
    end

    AST_WB_NOT_BAD: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> !bad_form_o); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> (!wb_en_o && !bad_form_o && ea_o == '0)); // R10
    AST_UPD_ZERO_BAD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid_i && upd_i && base_sel_i == '0) |-> bad_form_o); // R5
    AST_UPD_SAME_BAD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid_i && upd_i && base_sel_i == tgt_sel_i) |-> bad_form_o); // R6
    AST_PLAIN_NO_WB: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid_i && !upd_i) |-> (!wb_en_o && !bad_form_o)); // R8
    AST_PLAIN_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid_i && !upd_i && base_sel_i == '0 && scale_i == 2'd0)
        |-> ea_o == ($past(index_i) << 1)); // R2
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> out_valid_o == $past(in_valid_i)); // R10
endmodule

// File: tb/sidx_agen_bench.sv
module sidx_agen_bench;
    localparam int XLEN   = 64;
    localparam int RSEL_W = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid_i;
    logic [XLEN-1:0]   base_i, index_i;
    logic [RSEL_W-1:0] base_sel_i, tgt_sel_i;
    logic [1:0]        scale_i;
    logic              upd_i;
    logic              out_valid_o;
    logic [XLEN-1:0]   ea_o;
    logic              wb_en_o;
    logic [RSEL_W-1:0] wb_sel_o;
    logic              bad_form_o;

    always #5 clk = ~clk;

    sidx_agen #(.XLEN(XLEN), .RSEL_W(RSEL_W)) u_sidx_agen (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i),
        .base_i(base_i), .index_i(index_i),
        .base_sel_i(base_sel_i), .tgt_sel_i(tgt_sel_i),
        .scale_i(scale_i), .upd_i(upd_i),
        .out_valid_o(out_valid_o), .ea_o(ea_o), .wb_en_o(wb_en_o),
        .wb_sel_o(wb_sel_o), .bad_form_o(bad_form_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // expected results for the request driven on the previous falling edge
    logic              e_valid, e_wb, e_bad;
    logic [XLEN-1:0]   e_ea;
    logic [RSEL_W-1:0] e_sel;
    string             t_ea, t_wb, t_bad, t_valid;

    task automatic chk(input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(t_valid, "valid", XLEN'(out_valid_o), XLEN'(e_valid));
        chk(t_ea,    "ea",    ea_o,               e_ea);
        chk(t_wb,    "wb_en", XLEN'(wb_en_o),     XLEN'(e_wb));
        chk(t_wb,    "wb_sel", XLEN'(wb_sel_o),   XLEN'(e_sel));
        chk(t_bad,   "bad",   XLEN'(bad_form_o),  XLEN'(e_bad));
    endtask

    task automatic set_idle_expect(input string tag);
        e_valid = 0; e_ea = '0; e_wb = 0; e_sel = '0; e_bad = 0;
        t_ea = tag; t_wb = tag; t_bad = tag; t_valid = tag;
    endtask

    // drive one request, then check its result one clock later
    task automatic req(input logic v, input logic [XLEN-1:0] b,
                       input logic [XLEN-1:0] ix, input logic [RSEL_W-1:0] bs,
                       input logic [RSEL_W-1:0] ts, input logic [1:0] sc,
                       input logic u);
        logic [XLEN-1:0] bterm;
        logic            malformed;
        @(negedge clk);
        compare();
        in_valid_i = v; base_i = b; index_i = ix; base_sel_i = bs;
        tgt_sel_i = ts; scale_i = sc; upd_i = u;
        if (!v) begin
            set_idle_expect("R10");
        end else begin
            bterm = (!u && bs == 0) ? '0 : b;
            malformed = u && (bs == 0 || bs == ts);
            e_valid = 1;
            e_ea = bterm + (ix << (int'(sc) + 1));
            e_bad = malformed;
            e_wb = u && !malformed;
            e_sel = bs;
            t_valid = "R10";
            t_ea = u ? "R1" : (bs == 0 ? "R2" : "R3");
            t_bad = !u ? "R8" : (bs == 0 ? "R5" : (bs == ts ? "R6" : "R4"));
            t_wb = !u ? "R8" : (malformed ? "R7" : "R4");
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid_i = 0; base_i = '0; index_i = '0;
        base_sel_i = '0; tgt_sel_i = '0; scale_i = '0; upd_i = 0;
        set_idle_expect("R9");
        repeat (3) begin
            @(negedge clk);
            compare();
            in_valid_i = 1; base_i = 64'hdead; index_i = 64'h5;
            base_sel_i = 5'd3; upd_i = 1;
        end
        @(negedge clk);
        compare();
        rst = 0; in_valid_i = 0; upd_i = 0;
        set_idle_expect("R9");

        // every scale value, plain form with a nonzero base register
        for (int s = 0; s < 4; s++)
            req(1, 64'h1000, 64'h3, 5'd4, 5'd7, 2'(s), 0);
        // high index bits shifted out, each scale
        for (int s = 0; s < 4; s++)
            req(1, 64'h0, 64'hffff_ffff_ffff_ffff, 5'd2, 5'd9, 2'(s), 0);
        // wrapping sum
        req(1, 64'hffff_ffff_ffff_fffe, 64'h1, 5'd6, 5'd1, 2'd0, 0);
        req(1, 64'hffff_ffff_ffff_fff0, 64'h8, 5'd6, 5'd1, 2'd3, 1);
        // register zero as base in plain form ignores base value
        req(1, 64'habcd_1234, 64'h10, 5'd0, 5'd5, 2'd1, 0);
        req(1, 64'hffff_ffff_ffff_ffff, 64'h7, 5'd0, 5'd0, 2'd0, 0);
        // update form, well formed
        req(1, 64'h2000, 64'h4, 5'd8, 5'd9, 2'd2, 1);
        // update naming register zero
        req(1, 64'h2000, 64'h4, 5'd0, 5'd9, 2'd2, 1);
        // update with base equal to target
        req(1, 64'h3000, 64'h1, 5'd11, 5'd11, 2'd0, 1);
        // plain form with base equal to target is fine
        req(1, 64'h3000, 64'h1, 5'd11, 5'd11, 2'd0, 0);
        // idle gaps
        req(0, 64'h55, 64'h66, 5'd1, 5'd2, 2'd1, 1);
        req(0, 64'h0, 64'h0, 5'd0, 5'd0, 2'd0, 0);
        // pseudo-random run over a small register set
        for (int i = 0; i < 300; i++) begin
            logic [XLEN-1:0] rb, rx;
            rb = {$urandom(), $urandom()};
            rx = {$urandom(), $urandom()};
            req(($urandom() % 5) != 0, rb, rx, RSEL_W'($urandom() % 4),
                RSEL_W'($urandom() % 4), 2'($urandom() % 4), 1'($urandom() % 2));
        end
        req(0, '0, '0, '0, '0, '0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule